// File: doc/BRIEF.md
# Per-Port Receive Statistics Counters

This block keeps a set of receive statistics for each of a small number of ports. Once per received packet, the packet pipeline presents a single end-of-packet event. The event carries the port number, the byte length including CRC, and a set of qualifier flags: bad FCS, alignment error, dropped, multicast, broadcast, parsed-from-L2 and errored-upstream. From these the block classifies the packet and adds to the relevant counters of that port in the same clock edge. The classes are forwarded or dropped traffic, a length histogram, short and long frames split by FCS status, cast type, and inbound totals.

Software reaches the counters through a simple read port. It presents a port number and a counter index, and the value appears one cycle later. A global mode input turns every read into a read-and-clear. A clear that coincides with an update keeps that update, so no event is ever lost. Every counter saturates at its all-ones value. The inbound-octet counter and the inbound-error counter have their own widths, and all other counters share one width. All storage is in flip-flops, one saturating cell per counter per port.

Top module: `rmon_port_stats`

## Requirements
- R1: After reset every counter of every port reads 0, and `rd_valid` and `rd_data` are 0.
- R2: Every valid event adds `ev_len` to inbound octets (index 19, WIDE_W bits). When `ev_upstream_err` is 1 it adds 1 to inbound errors (index 20, ERR_W bits); otherwise it adds 1 to inbound good packets (index 18).
- R3: A valid event with `ev_drop`=1 adds 1 to dropped packets (index 2) and max(len-CRC_BYTES,0) to dropped octets (index 3). Otherwise the same amounts go to forwarded packets (index 0) and forwarded octets (index 1).
- R4: Each valid event of length at least MIN_LEN adds 1 to exactly one histogram bin. The bins are: 64 bytes (index 6), 65-127 (7), 128-255 (8), 256-511 (9), 512-1023 (10), 1024-MAX_LEN (11) and anything above MAX_LEN (12). Shorter events touch no bin.
- R5: A valid event shorter than MIN_LEN adds 1 to runts (index 14) when `ev_fcs_bad`=0, and to fragments (index 15) when `ev_fcs_bad`=1.
- R6: A valid event longer than MAX_LEN adds 1 to oversize (index 16) when `ev_fcs_bad`=0, and to jabber (index 17) when `ev_fcs_bad`=1.
- R7: A valid event with length in [MIN_LEN, MAX_LEN] and with `ev_fcs_bad` or `ev_align_bad` set adds 1 to the FCS/alignment counter (index 13).
- R8: Broadcast (index 5) and multicast (index 4) count only when `ev_l2_parse`=1. When both flags are set, only broadcast counts.
- R9: `rd_en` at a clock edge loads `rd_data` after that edge with the selected counter's value from before that edge's update, and raises `rd_valid` for one cycle. A port of NPORTS or more, or an index of 21 or more, returns 0. `rd_data` holds its value between reads.
- R10: While `rd_clr_mode`=1 a read resets the counter it selects and no other counter. While `rd_clr_mode`=0 a read changes nothing.
- R11: When a clearing read and an event update hit the same counter in one cycle, the read returns the old value and the counter becomes the event's increment.
- R12: Counters saturate at all ones and never wrap.
- R13: With `ev_valid`=0, or with `ev_port` of NPORTS or more, no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | End-of-packet event strobe |
| ev_port | input | PORT_W | Port the packet arrived on |
| ev_len | input | LEN_W | Packet length in bytes, CRC included |
| ev_fcs_bad | input | 1 | Packet failed FCS |
| ev_align_bad | input | 1 | Packet had an alignment error |
| ev_drop | input | 1 | Packet marked for drop |
| ev_mcast | input | 1 | Destination is multicast |
| ev_bcast | input | 1 | Destination is broadcast |
| ev_l2_parse | input | 1 | Packet was parsed from its L2 header |
| ev_upstream_err | input | 1 | Receive logic flagged an error |
| rd_clr_mode | input | 1 | Global read-and-clear mode |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_W | Port to read |
| rd_sel | input | 5 | Counter index to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 64 | Counter value, zero-extended |

## Verification
A wrong classification in this block stays invisible until a counter is read. Every counter a scenario could have touched is therefore read back on the port after that scenario, and the first misrouted or missing increment shows up one cycle after its read. Clear, saturation and same-cycle collision faults appear on the next read of that counter. Because of this, those reads are placed right after the event that exercises them. Index or port decode faults appear as a nonzero value on out-of-range reads, or as a changed neighbour counter.

// File: rtl/rmon_stat_pkg.sv
package rmon_stat_pkg;

  localparam int NCNT  = 21;
  localparam int SEL_W = 5;
  localparam int VAL_W = 64;
  localparam int NBKT  = 7;

  // Fixed histogram edges between MIN_LEN and MAX_LEN
  localparam int EDGE_127  = 127;
  localparam int EDGE_255  = 255;
  localparam int EDGE_511  = 511;
  localparam int EDGE_1023 = 1023;

  typedef enum logic [SEL_W-1:0] {
    CI_PKTS      = 5'd0,
    CI_OCTS      = 5'd1,
    CI_DROP_PKTS = 5'd2,
    CI_DROP_OCTS = 5'd3,
    CI_MCAST     = 5'd4,
    CI_BCAST     = 5'd5,
    CI_B64       = 5'd6,
    CI_B65       = 5'd7,
    CI_B128      = 5'd8,
    CI_B256      = 5'd9,
    CI_B512      = 5'd10,
    CI_B1024     = 5'd11,
    CI_BBIG      = 5'd12,
    CI_BAD_FCS   = 5'd13,
    CI_RUNT      = 5'd14,
    CI_FRAG      = 5'd15,
    CI_OVER      = 5'd16,
    CI_JABBER    = 5'd17,
    CI_INB_PKTS  = 5'd18,
    CI_INB_OCTS  = 5'd19,
    CI_INB_ERRS  = 5'd20
  } cnt_idx_e;

  // Storage width of counter idx
  function automatic int cnt_width(int idx, int base_w, int wide_w, int err_w);
    if (idx == int'(CI_INB_OCTS)) return wide_w;
    if (idx == int'(CI_INB_ERRS)) return err_w;
    return base_w;
  endfunction

  // Saturating add limited to w bits
  function automatic logic [VAL_W-1:0] sat_add(logic [VAL_W-1:0] cur,
                                               logic [VAL_W-1:0] amt, int w);
    logic [VAL_W:0]   sum;
    logic [VAL_W-1:0] lim;
    lim = (w >= VAL_W) ? '1 : ((VAL_W'(1) << w) - VAL_W'(1));
    sum = {1'b0, cur} + {1'b0, amt};
    if (sum[VAL_W] || (sum[VAL_W-1:0] > lim)) return lim;
    return sum[VAL_W-1:0];
  endfunction

  // Histogram bin 0..NBKT-1, or -1 when below the minimum length
  function automatic int bucket_of(int len, int min_len, int max_len);
    if (len < min_len)    return -1;
    if (len == min_len)   return 0;
    if (len <= EDGE_127)  return 1;
    if (len <= EDGE_255)  return 2;
    if (len <= EDGE_511)  return 3;
    if (len <= EDGE_1023) return 4;
    if (len <= max_len)   return 5;
    return 6;
  endfunction

  // Payload octets without the trailing CRC, floored at zero
  function automatic int net_octets(int len, int crc_bytes);
    return (len >= crc_bytes) ? (len - crc_bytes) : 0;
  endfunction

endpackage

// File: rtl/rmon_ev_classify.sv
module rmon_ev_classify
  import rmon_stat_pkg::*;
#(
  parameter int LEN_W     = 14,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1518,
  parameter int CRC_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ev_valid_i,
  input  logic [LEN_W-1:0]           ev_len_i,
  input  logic                       ev_fcs_bad_i,
  input  logic                       ev_align_bad_i,
  input  logic                       ev_drop_i,
  input  logic                       ev_mcast_i,
  input  logic                       ev_bcast_i,
  input  logic                       ev_l2_i,
  input  logic                       ev_uperr_i,
  output logic [NCNT-1:0][LEN_W-1:0] amt_o
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  int               len_v;
  int               bkt_v;
  logic [LEN_W-1:0] net_v;
  logic [NCNT-1:0]  hit;

  always_comb begin
    amt_o = '0;
    len_v = int'(ev_len_i);
    bkt_v = bucket_of(len_v, MIN_LEN, MAX_LEN);
    net_v = LEN_W'(net_octets(len_v, CRC_BYTES));
    if (ev_valid_i) begin
      amt_o[CI_INB_OCTS] = ev_len_i;
      if (ev_uperr_i) amt_o[CI_INB_ERRS] = ONE;
      else            amt_o[CI_INB_PKTS] = ONE;

      if (ev_drop_i) begin
        amt_o[CI_DROP_PKTS] = ONE;
        amt_o[CI_DROP_OCTS] = net_v;
      end else begin
        amt_o[CI_PKTS] = ONE;
        amt_o[CI_OCTS] = net_v;
      end

      if (ev_l2_i) begin
        if (ev_bcast_i)      amt_o[CI_BCAST] = ONE;
        else if (ev_mcast_i) amt_o[CI_MCAST] = ONE;
      end

      if (bkt_v >= 0) amt_o[int'(CI_B64) + bkt_v] = ONE;

      if (len_v < MIN_LEN) begin
        if (ev_fcs_bad_i) amt_o[CI_FRAG] = ONE;
        else              amt_o[CI_RUNT] = ONE;
      end else if (len_v > MAX_LEN) begin
        if (ev_fcs_bad_i) amt_o[CI_JABBER] = ONE;
        else              amt_o[CI_OVER]   = ONE;
      end else if (ev_fcs_bad_i || ev_align_bad_i) begin
        amt_o[CI_BAD_FCS] = ONE;
      end
    end
  end

  // Per-counter "touched" events, brought out for the checks below
  for (genvar k = 0; k < NCNT; k++) begin : g_hit
    assign hit[k] = |amt_o[k];
  end

  AST_ONE_BUCKET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_i && (int'(ev_len_i) >= MIN_LEN)) |-> ($countones(hit[CI_BBIG:CI_B64]) == 1)); // R4
  AST_NO_BUCKET_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ev_len_i) < MIN_LEN) |-> (hit[CI_BBIG:CI_B64] == '0)); // R4
  AST_LEN_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit[CI_BAD_FCS], hit[CI_RUNT], hit[CI_FRAG], hit[CI_OVER], hit[CI_JABBER]})); // R7
  AST_CAST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit[CI_MCAST] && hit[CI_BCAST])); // R8
  AST_CAST_NEEDS_L2: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_l2_i |-> !(hit[CI_MCAST] || hit[CI_BCAST])); // R8
  AST_INB_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_i |-> (hit[CI_INB_PKTS] != hit[CI_INB_ERRS])); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid_i |-> (hit == '0)); // R13

endmodule

// File: rtl/rmon_stat_cell.sv
module rmon_stat_cell
  import rmon_stat_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             clr_i,
  output logic [VAL_W-1:0] val_o
);

  logic [W-1:0]     q;
  logic [VAL_W-1:0] base;
  logic [VAL_W-1:0] nxt;

  // A clear drops the old value but keeps this cycle's increment
  always_comb begin
    base = '0;
    if (!clr_i) base[W-1:0] = q;
    nxt = sat_add(base, VAL_W'(amt_i), W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
  end

  always_comb begin
    val_o = '0;
    val_o[W-1:0] = q;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (val_o >= $past(val_o))); // R12
  AST_CLR_KEEPS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (val_o == VAL_W'($past(amt_i)))); // R11

endmodule

// File: rtl/rmon_rd_mux.sv
module rmon_rd_mux
  import rmon_stat_pkg::*;
#(
  parameter int NPORTS = 6,
  parameter int PORT_W = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   rd_en_i,
  input  logic [PORT_W-1:0]                      rd_port_i,
  input  logic [SEL_W-1:0]                       rd_sel_i,
  input  logic [NPORTS-1:0][NCNT-1:0][VAL_W-1:0] vals_i,
  output logic                                   rd_valid_o,
  output logic [VAL_W-1:0]                       rd_data_o
);

  logic in_range;
  assign in_range = (int'(rd_port_i) < NPORTS) && (int'(rd_sel_i) < NCNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= in_range ? vals_i[rd_port_i][rd_sel_i] : '0;
    end
  end

  AST_RD_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !in_range) |=> (rd_data_o == '0)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o)); // R9

endmodule

// File: rtl/rmon_port_stats.sv
module rmon_port_stats
  import rmon_stat_pkg::*;
#(
  parameter int  NPORTS    = 6,
  parameter int  CNT_W     = 32,
  parameter int  WIDE_W    = 64,
  parameter int  ERR_W     = 16,
  parameter int  LEN_W     = 14,
  parameter int  MIN_LEN   = 64,
  parameter int  MAX_LEN   = 1518,
  parameter int  CRC_BYTES = 4,
  localparam int PORT_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [PORT_W-1:0] ev_port,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              ev_fcs_bad,
  input  logic              ev_align_bad,
  input  logic              ev_drop,
  input  logic              ev_mcast,
  input  logic              ev_bcast,
  input  logic              ev_l2_parse,
  input  logic              ev_upstream_err,
  input  logic              rd_clr_mode,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic              rd_valid,
  output logic [VAL_W-1:0]  rd_data
);

  localparam int NCELL = NPORTS * NCNT;

  logic [NCNT-1:0][LEN_W-1:0]            cls_amt;
  logic [NPORTS-1:0][NCNT-1:0][VAL_W-1:0] vals;
  logic [NCELL-1:0]                       clr_vec;

  rmon_ev_classify #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CRC_BYTES(CRC_BYTES)
  ) u_classify (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_valid_i     (ev_valid),
    .ev_len_i       (ev_len),
    .ev_fcs_bad_i   (ev_fcs_bad),
    .ev_align_bad_i (ev_align_bad),
    .ev_drop_i      (ev_drop),
    .ev_mcast_i     (ev_mcast),
    .ev_bcast_i     (ev_bcast),
    .ev_l2_i        (ev_l2_parse),
    .ev_uperr_i     (ev_upstream_err),
    .amt_o          (cls_amt)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic port_hit;
    assign port_hit = (int'(ev_port) == p);
    for (genvar k = 0; k < NCNT; k++) begin : g_cnt
      localparam int CW = cnt_width(k, CNT_W, WIDE_W, ERR_W);
      logic [LEN_W-1:0] amt;
      logic             clr;
      assign amt = port_hit ? cls_amt[k] : '0;
      assign clr = rd_en && rd_clr_mode && (int'(rd_port) == p) && (int'(rd_sel) == k);
      assign clr_vec[p*NCNT + k] = clr;
      rmon_stat_cell #(.W(CW), .AMT_W(LEN_W)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .amt_i (amt),
        .clr_i (clr),
        .val_o (vals[p][k])
      );
    end
  end

  rmon_rd_mux #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_rd_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en),
    .rd_port_i  (rd_port),
    .rd_sel_i   (rd_sel),
    .vals_i     (vals),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec)); // R10
  AST_NO_CLR_IN_KEEP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_mode |-> (clr_vec == '0)); // R10

endmodule

// File: tb/tb_rmon_port_stats.sv
module tb_rmon_port_stats;

  localparam int CLK_PERIOD = 10;
  localparam int NP   = 6;
  localparam int NC   = 21;
  localparam int CW   = 16;
  localparam int WW   = 40;
  localparam int EW   = 8;
  localparam int LW   = 14;
  localparam int PW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [PW-1:0] ev_port = '0;
  logic [LW-1:0] ev_len = '0;
  logic ev_fcs_bad = 1'b0, ev_align_bad = 1'b0, ev_drop = 1'b0;
  logic ev_mcast = 1'b0, ev_bcast = 1'b0, ev_l2_parse = 1'b0, ev_upstream_err = 1'b0;
  logic rd_clr_mode = 1'b0, rd_en = 1'b0;
  logic [PW-1:0] rd_port = '0;
  logic [4:0] rd_sel = '0;
  logic rd_valid;
  logic [63:0] rd_data;

  int vectors = 0;
  int miscompares = 0;
  longint unsigned expv [NP][NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  rmon_port_stats #(
    .NPORTS(NP), .CNT_W(CW), .WIDE_W(WW), .ERR_W(EW), .LEN_W(LW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_port(ev_port), .ev_len(ev_len),
    .ev_fcs_bad(ev_fcs_bad), .ev_align_bad(ev_align_bad), .ev_drop(ev_drop),
    .ev_mcast(ev_mcast), .ev_bcast(ev_bcast), .ev_l2_parse(ev_l2_parse),
    .ev_upstream_err(ev_upstream_err), .rd_clr_mode(rd_clr_mode), .rd_en(rd_en),
    .rd_port(rd_port), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic longint unsigned ceiling(int idx);
    int w;
    w = (idx == 19) ? WW : ((idx == 20) ? EW : CW);
    return (longint'(1) << w) - 1;
  endfunction

  function automatic string req_of(int idx);
    if (idx <= 3)  return "R3";
    if (idx <= 5)  return "R8";
    if (idx <= 12) return "R4";
    if (idx == 13) return "R7";
    if (idx <= 15) return "R5";
    if (idx <= 17) return "R6";
    return "R2";
  endfunction

  function automatic void bump(int p, int idx, longint unsigned a);
    longint unsigned s;
    s = expv[p][idx] + a;
    expv[p][idx] = (s > ceiling(idx)) ? ceiling(idx) : s;
  endfunction

  // Reference model written straight from the requirements
  function automatic void model(int p, int len, bit fcs, bit aln, bit drp,
                                bit mc, bit bc, bit l2, bit ue);
    longint unsigned net;
    if (p >= NP) return;
    net = (len < 4) ? 0 : longint'(len - 4);
    bump(p, 19, longint'(len));
    bump(p, ue ? 20 : 18, 1);
    bump(p, drp ? 2 : 0, 1);
    bump(p, drp ? 3 : 1, net);
    if (l2 && bc)      bump(p, 5, 1);
    else if (l2 && mc) bump(p, 4, 1);
    if (len > 1518)      bump(p, 12, 1);
    else if (len > 1023) bump(p, 11, 1);
    else if (len > 511)  bump(p, 10, 1);
    else if (len > 255)  bump(p, 9, 1);
    else if (len > 127)  bump(p, 8, 1);
    else if (len > 64)   bump(p, 7, 1);
    else if (len == 64)  bump(p, 6, 1);
    if (len < 64)        bump(p, fcs ? 15 : 14, 1);
    else if (len > 1518) bump(p, fcs ? 17 : 16, 1);
    else if (fcs || aln) bump(p, 13, 1);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_ev(int p, int len, bit fcs, bit aln, bit drp,
                          bit mc, bit bc, bit l2, bit ue);
    ev_valid = 1'b1; ev_port = PW'(p); ev_len = LW'(len);
    ev_fcs_bad = fcs; ev_align_bad = aln; ev_drop = drp;
    ev_mcast = mc; ev_bcast = bc; ev_l2_parse = l2; ev_upstream_err = ue;
  endtask

  task automatic send(int p, int len, bit fcs, bit aln, bit drp,
                      bit mc, bit bc, bit l2, bit ue);
    @(negedge clk);
    drive_ev(p, len, fcs, aln, drp, mc, bc, l2, ue);
    @(negedge clk);
    ev_valid = 1'b0;
    model(p, len, fcs, aln, drp, mc, bc, l2, ue);
  endtask

  task automatic rd(int p, int s, output logic [63:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_port = PW'(p); rd_sel = 5'(s);
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
    if (rd_valid !== 1'b1) chk("R9", "rd_valid after read", {63'd0, rd_valid}, 64'd1);
  endtask

  task automatic check_port(int p, string tag);
    logic [63:0] v;
    for (int k = 0; k < NC; k++) begin
      rd(p, k, v);
      chk(req_of(k), $sformatf("%s port%0d idx%0d", tag, p, k), v, expv[p][k]);
    end
  endtask

  task automatic t_reset();
    chk("R1", "rd_valid at reset", {63'd0, rd_valid}, 64'd0);
    chk("R1", "rd_data at reset", rd_data, 64'd0);
    check_port(0, "R1 reset");
    check_port(NP-1, "R1 reset");
  endtask

  task automatic t_classify();
    send(1, 64,   0, 0, 0, 0, 0, 1, 0);
    send(1, 100,  0, 0, 1, 0, 0, 1, 0);
    send(1, 300,  0, 0, 0, 1, 0, 1, 0);
    send(1, 600,  0, 0, 0, 0, 1, 1, 0);
    send(1, 1200, 0, 0, 0, 1, 0, 0, 0);
    send(1, 1518, 0, 0, 0, 1, 1, 1, 0);
    send(1, 1519, 0, 0, 0, 0, 0, 0, 0);
    send(1, 2000, 0, 0, 0, 0, 0, 0, 0);
    send(1, 3000, 1, 0, 0, 0, 0, 0, 0);
    send(1, 40,   0, 0, 0, 0, 0, 0, 0);
    send(1, 30,   1, 0, 1, 0, 0, 0, 0);
    send(1, 200,  0, 1, 0, 0, 0, 0, 0);
    send(1, 1000, 1, 0, 0, 0, 0, 0, 1);
    send(1, 65,   0, 0, 0, 0, 0, 0, 1);
    send(1, 2,    0, 0, 1, 0, 0, 0, 0);
    send(3, 127,  0, 0, 0, 1, 0, 1, 0);
    send(3, 128,  0, 0, 0, 0, 0, 0, 0);
    send(3, 1023, 1, 1, 0, 0, 0, 0, 0);
    send(3, 1024, 0, 0, 0, 0, 0, 0, 0);
    send(3, 63,   0, 0, 0, 0, 0, 0, 0);
    check_port(1, "classify");
    check_port(3, "classify edges");
    check_port(0, "classify neighbour");
  endtask

  task automatic t_idle();
    @(negedge clk);
    drive_ev(1, 500, 1, 1, 1, 1, 1, 1, 1);
    ev_valid = 1'b0;
    repeat (4) @(negedge clk);
    drive_ev(7, 500, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    ev_valid = 1'b0;
    model(7, 500, 0, 0, 0, 0, 0, 0, 0);
    for (int p = 0; p < NP; p++) check_port(p, "R13 idle/out-of-range event");
  endtask

  task automatic t_read();
    logic [63:0] v, w;
    rd(6, 0, v);  chk("R9", "port 6 out of range", v, 64'd0);
    rd(1, 21, v); chk("R9", "index 21 out of range", v, 64'd0);
    rd(1, 31, v); chk("R9", "index 31 out of range", v, 64'd0);
    rd(1, 19, v);
    repeat (3) @(negedge clk);
    chk("R9", "rd_valid drops after one cycle", {63'd0, rd_valid}, 64'd0);
    chk("R9", "rd_data held between reads", rd_data, expv[1][19]);
    rd(1, 1, v); rd(1, 1, w);
    chk("R10", "keep-mode read 1", v, expv[1][1]);
    chk("R10", "keep-mode read 2", w, expv[1][1]);
  endtask

  task automatic t_clear();
    logic [63:0] v;
    rd_clr_mode = 1'b1;
    rd(1, 19, v);
    chk("R10", "clearing read returns value", v, expv[1][19]);
    expv[1][19] = 0;
    rd(1, 19, v);
    chk("R10", "counter zero after clearing read", v, 64'd0);
    rd(1, 4, v);
    chk("R10", "clearing read of mcast", v, expv[1][4]);
    expv[1][4] = 0;
    rd_clr_mode = 1'b0;
    check_port(1, "R10 after clear");
    check_port(3, "R10 other port untouched");
  endtask

  task automatic t_same_cycle();
    logic [63:0] v;
    repeat (3) send(2, 100, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    drive_ev(2, 100, 0, 0, 0, 0, 0, 0, 0);
    rd_clr_mode = 1'b1; rd_en = 1'b1; rd_port = 3'd2; rd_sel = 5'd0;
    @(negedge clk);
    ev_valid = 1'b0; rd_en = 1'b0; rd_clr_mode = 1'b0;
    chk("R11", "collision read returns old value", rd_data, expv[2][0]);
    expv[2][0] = 0;
    model(2, 100, 0, 0, 0, 0, 0, 0, 0);
    rd(2, 0, v);
    chk("R11", "collision keeps increment", v, 64'd1);
    check_port(2, "R11 after collision");
  endtask

  task automatic t_saturate();
    logic [63:0] v;
    for (int i = 0; i < 260; i++) send(4, 1500, 0, 0, 0, 0, 0, 0, 1);
    rd(4, 20, v); chk("R12", "error counter saturates", v, 64'd255);
    rd(4, 1, v);  chk("R12", "octet counter saturates", v, 64'd65535);
    send(4, 1500, 0, 0, 0, 0, 0, 0, 1);
    rd(4, 20, v); chk("R12", "error counter stays at max", v, 64'd255);
    check_port(4, "R12 saturation");
  endtask

  initial begin
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < NC; k++) expv[p][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_classify();
    t_idle();
    t_read();
    t_clear();
    t_same_cycle();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule